// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point numbers and returns a rounded 32-bit sum. It also reports overflow and underflow. A caller presents both operands with a one-cycle `start` strobe while the block is idle. The block then works through a short sequence of steps:

1. An exponent comparator chooses the operand of larger magnitude and the exponent gap.
2. The smaller significand is shifted right by that gap into a field three bits wider than the significand. The three extra bits are guard, round and sticky.
3. The significands are added or subtracted.
4. The raw sum is normalized.
5. The result is rounded to nearest with ties to even.
6. If rounding carried out of the significand, one extra normalization step runs before the result is packed.

When the result is ready, `done` pulses for one cycle. The result and the flags then hold until the next `done`.

Only normal numbers and zero are handled. An operand whose exponent field is zero is treated as zero, whatever its fraction bits. The block has no rounding-mode selection. Infinity and NaN operands are not recognised.

Top module: `fpa_add32`

## Requirements
- R1: `start` is sampled only while the block is idle, and a `start` seen while busy is ignored. `done` is high for exactly one cycle per accepted operation. `sum`, `ovf` and `unf` hold their values until the next `done`.
- R2: A word carries the sign in bit 31, a biased exponent (bias 127) in bits 30:23 and the fraction in bits 22:0, with a hidden leading 1. An operand whose exponent field is 0 counts as zero, and its fraction bits have no effect on the result.
- R3: When the operands have the same sign, the magnitudes are added after the smaller one is shifted right by the exponent difference, and the sign is kept. A carry out of the significand shifts the sum right by one and raises the exponent by one.
- R4: When the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. Leading zeros are removed by a left shift that lowers the exponent by the shift amount. An exact zero result is +0 (0x00000000), and this includes the sum of two zeros.
- R5: The result is rounded to nearest with ties to even, decided from the guard, round and sticky bits that lie below the kept 24-bit significand.
- R6: If the exponent difference is 27 or more, the smaller operand contributes only to the sticky bit.
- R7: If rounding carries out of the significand, a second normalization step shifts the significand right and raises the exponent by one. `done` rises on the fourth rising edge after the edge that samples `start`, or on the fifth when this extra step runs.
- R8: A final biased exponent of 255 or more sets `ovf` and returns the sign followed by exponent 0xFF and fraction 0. `unf` stays low in this case.
- R9: A final biased exponent of 0 or less on a nonzero result sets `unf` and returns the sign followed by 31 zero bits. `ovf` stays low in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an addition with `op_a` and `op_b` (sampled when idle) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| done | output | 1 | One-cycle pulse: `sum` and flags are new |
| sum | output | 32 | Rounded sum |
| ovf | output | 1 | Result exponent too large |
| unf | output | 1 | Result exponent too small for a normal number |

## Verification
Directed operand pairs exercise each path separately:
- Same-sign pairs with and without a significand carry tell right-shift normalization apart from no shift.
- Opposite-sign pairs that cancel a single leading bit, or every bit, tell the left-shift path apart from the exact-zero rule.
- Four pairs near one unit in the last place separate the rounding decisions: below half, above half, a tie on an even LSB and a tie on an odd LSB.
- An all-ones significand rounded up shows the renormalization step by its result and by its extra cycle.
- A far-apart subtraction shows the sticky-only contribution forcing that same step.
- Sums near the largest and smallest normal exponents separate overflow and underflow, including an overflow that only appears after rounding.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD,
        ST_NORM,
        ST_RND,
        ST_RENORM,
        ST_FIN
    } fpa_state_e;
endpackage

// File: rtl/fpa_expcmp.sv
module fpa_expcmp #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              big_sign,
    output logic              eff_sub,
    output logic [EXP_W-1:0]  big_exp,
    output logic [EXP_W-1:0]  diff,
    output logic [SIG_W-1:0]  big_sig,
    output logic [SIG_W-1:0]  sml_sig
);
    logic [WORD_W-2:0] mag_a, mag_b;
    logic [EXP_W-1:0]  ea, eb, sml_exp;
    logic              a_ge;

    always_comb begin
        ea    = a[WORD_W-2 -: EXP_W];
        eb    = b[WORD_W-2 -: EXP_W];
        mag_a = (ea == '0) ? '0 : a[WORD_W-2:0];
        mag_b = (eb == '0) ? '0 : b[WORD_W-2:0];
        a_ge  = (mag_a >= mag_b);
        big_sign = a_ge ? a[WORD_W-1] : b[WORD_W-1];
        eff_sub  = a[WORD_W-1] ^ b[WORD_W-1];
        big_exp  = a_ge ? ea : eb;
        sml_exp  = a_ge ? eb : ea;
        diff     = big_exp - sml_exp;
        big_sig  = a_ge ? {(ea != '0), mag_a[FRAC_W-1:0]} : {(eb != '0), mag_b[FRAC_W-1:0]};
        sml_sig  = a_ge ? {(eb != '0), mag_b[FRAC_W-1:0]} : {(ea != '0), mag_a[FRAC_W-1:0]};
        // R4: a zero larger operand implies a zero smaller operand
        a_r4_zero_order: assert (big_sig != '0 || sml_sig == '0)
            else $error("a_r4_zero_order");
    end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int SIG_W = 24,
    parameter int SH_W  = 8,
    localparam int EXT_W = SIG_W + 3
) (
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [EXT_W-1:0] ext
);
    logic [EXT_W-1:0] full, shifted;
    logic             lost;

    always_comb begin
        full    = {sig, 3'b000};
        shifted = full >> shamt;
        lost    = |(full & ~({EXT_W{1'b1}} << shamt));
        if (int'(shamt) >= EXT_W) begin
            ext = {{(EXT_W-1){1'b0}}, |sig};
        end else begin
            ext = shifted | {{(EXT_W-1){1'b0}}, lost};
        end
        // R6: no nonzero operand disappears entirely during alignment
        a_r6_sticky_keeps: assert ((sig == '0) == (ext == '0))
            else $error("a_r6_sticky_keeps");
    end
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm #(
    parameter int EXT_W = 27,
    parameter int EI_W  = 10,
    localparam int LZ_W = $clog2(EXT_W)
) (
    input  logic [EXT_W:0]   raw,
    input  logic [EI_W-1:0]  exp_in,
    output logic [EXT_W-1:0] mant,
    output logic [EI_W-1:0]  exp_out,
    output logic             zero
);
    logic [LZ_W-1:0] lz;
    logic            found;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!found && raw[i]) begin
                lz    = LZ_W'(EXT_W - 1 - i);
                found = 1'b1;
            end
        end
        zero = (raw == '0);
        if (raw[EXT_W]) begin
            mant    = {raw[EXT_W:2], raw[1] | raw[0]};
            exp_out = exp_in + EI_W'(1);
        end else begin
            mant    = raw[EXT_W-1:0] << lz;
            exp_out = exp_in - EI_W'(lz);
        end
        // R3/R4: a nonzero sum leaves normalization with its leading one on top
        a_r4_norm_lead: assert (zero || mant[EXT_W-1])
            else $error("a_r4_norm_lead");
    end
endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
    parameter int SIG_W = 24,
    localparam int EXT_W = SIG_W + 3
) (
    input  logic [EXT_W-1:0] mant,
    output logic [SIG_W:0]   rnd
);
    logic up;

    always_comb begin
        up  = mant[2] & (mant[1] | mant[0] | mant[3]);
        rnd = {1'b0, mant[EXT_W-1:3]} + {{SIG_W{1'b0}}, up};
        // R7: a carry out of rounding only comes from an all-ones significand
        a_r7_carry_from_ones: assert (!rnd[SIG_W] || (&mant[EXT_W-1:3]))
            else $error("a_r7_carry_from_ones");
    end
endmodule

// File: rtl/fpa_add32.sv
module fpa_add32 #(
    parameter int EXP_W  = fpa_pkg::EXP_W,
    parameter int FRAC_W = fpa_pkg::FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              done,
    output logic [WORD_W-1:0] sum,
    output logic              ovf,
    output logic              unf
);
    import fpa_pkg::*;

    localparam int SIG_W   = FRAC_W + 1;
    localparam int EXT_W   = SIG_W + 3;
    localparam int EI_W    = EXP_W + 2;
    localparam logic signed [EI_W-1:0] EXP_TOP = EI_W'((1 << EXP_W) - 1);
    localparam logic signed [EI_W-1:0] EXP_ONE = EI_W'(1);

    typedef struct packed {
        fpa_state_e        st;
        logic              sign;
        logic              eff_sub;
        logic [EI_W-1:0]   exp;
        logic [EXT_W-1:0]  big;
        logic [EXT_W-1:0]  sml;
        logic [EXT_W:0]    raw;
        logic [EXT_W-1:0]  mant;
        logic              zero;
        logic [SIG_W:0]    rnd;
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              unf;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic              c_sign, c_sub;
    logic [EXP_W-1:0]  c_exp, c_diff;
    logic [SIG_W-1:0]  c_big, c_sml;
    logic [EXT_W-1:0]  al_sml;
    logic [EXT_W-1:0]  n_mant;
    logic [EI_W-1:0]   n_exp;
    logic              n_zero;
    logic [SIG_W:0]    rnd_w;

    fpa_expcmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
        .a(op_a), .b(op_b), .big_sign(c_sign), .eff_sub(c_sub),
        .big_exp(c_exp), .diff(c_diff), .big_sig(c_big), .sml_sig(c_sml)
    );

    fpa_align #(.SIG_W(SIG_W), .SH_W(EXP_W)) u_align (
        .sig(c_sml), .shamt(c_diff), .ext(al_sml)
    );

    fpa_norm #(.EXT_W(EXT_W), .EI_W(EI_W)) u_norm (
        .raw(r_q.raw), .exp_in(r_q.exp), .mant(n_mant), .exp_out(n_exp), .zero(n_zero)
    );

    fpa_round #(.SIG_W(SIG_W)) u_round (
        .mant(r_q.mant), .rnd(rnd_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.sign    = c_sign;
                    r_d.eff_sub = c_sub;
                    r_d.exp     = EI_W'(c_exp);
                    r_d.big     = {c_big, 3'b000};
                    r_d.sml     = al_sml;
                    r_d.st      = ST_ADD;
                end
            end
            ST_ADD: begin
                r_d.raw = r_q.eff_sub ? ({1'b0, r_q.big} - {1'b0, r_q.sml})
                                      : ({1'b0, r_q.big} + {1'b0, r_q.sml});
                r_d.st  = ST_NORM;
            end
            ST_NORM: begin
                r_d.mant = n_mant;
                r_d.exp  = n_exp;
                r_d.zero = n_zero;
                r_d.st   = ST_RND;
            end
            ST_RND: begin
                r_d.rnd = rnd_w;
                r_d.st  = rnd_w[SIG_W] ? ST_RENORM : ST_FIN;
            end
            ST_RENORM: begin
                r_d.rnd = {1'b0, r_q.rnd[SIG_W:1]};
                r_d.exp = r_q.exp + EI_W'(1);
                r_d.st  = ST_FIN;
            end
            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                r_d.ovf  = 1'b0;
                r_d.unf  = 1'b0;
                if (r_q.zero) begin
                    r_d.res = '0;
                end else if ($signed(r_q.exp) >= EXP_TOP) begin
                    r_d.res = {r_q.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    r_d.ovf = 1'b1;
                end else if ($signed(r_q.exp) < EXP_ONE) begin
                    r_d.res = {r_q.sign, {(WORD_W-1){1'b0}}};
                    r_d.unf = 1'b1;
                end else begin
                    r_d.res = {r_q.sign, r_q.exp[EXP_W-1:0], r_q.rnd[FRAC_W-1:0]};
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;
    assign sum  = r_q.res;
    assign ovf  = r_q.ovf;
    assign unf  = r_q.unf;

    a_r1_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("a_r1_done_one_cycle");

    a_r1_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(r_q.st) == ST_FIN) else $error("a_r1_done_after_fin");

    a_r7_renorm_after_round: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RENORM) |-> $past(r_q.st) == ST_RND) else $error("a_r7_renorm_after_round");

    a_r8_ovf_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (sum[WORD_W-2:FRAC_W] == {EXP_W{1'b1}} && sum[FRAC_W-1:0] == '0))
        else $error("a_r8_ovf_pattern");

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf)) else $error("a_r8_flags_exclusive");

    a_r9_unf_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> sum[WORD_W-2:0] == '0) else $error("a_r9_unf_pattern");
endmodule

// File: tb/fpa_add32_tb.sv
`timescale 1ns/100ps
module fpa_add32_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        done;
    logic [31:0] sum;
    logic        ovf, unf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fpa_add32 dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .done(done), .sum(sum), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    // issue one add, wait for done, check result, flags and latency
    task automatic run_case(input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] e_sum, input bit e_ovf, input bit e_unf,
                            input int e_lat, input string req);
        int lat;
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(sum == e_sum, req, "sum", sum, e_sum);
        chk(ovf == e_ovf && unf == e_unf, req, "flags {ovf,unf}",
            {30'd0, ovf, unf}, {30'd0, e_ovf, e_unf});
        chk(lat == e_lat, "R7", "latency", lat, e_lat);
        @(negedge clk);
        chk(!done, "R1", "done width", {31'd0, done}, 32'd0);
        chk(sum == e_sum, "R1", "sum held", sum, e_sum);
    endtask

    task automatic t_reset;
        chk(done == 1'b0 && ovf == 1'b0 && unf == 1'b0, "R1", "reset flags",
            {29'd0, done, ovf, unf}, 32'd0);
        chk(sum == 32'd0, "R1", "reset sum", sum, 32'd0);
    endtask

    task automatic t_like_sign;
        run_case(32'h3F800000, 32'h3F800000, 32'h40000000, 0, 0, 4, "R3");
        run_case(32'h3FC00000, 32'h40200000, 32'h40800000, 0, 0, 4, "R3");
        run_case(32'h3FC00000, 32'h3FC00000, 32'h40400000, 0, 0, 4, "R3");
    endtask

    task automatic t_unlike_sign;
        run_case(32'h40400000, 32'hBF800000, 32'h40000000, 0, 0, 4, "R4");
        run_case(32'hC0400000, 32'h3F800000, 32'hC0000000, 0, 0, 4, "R4");
        run_case(32'h3F800001, 32'hBF800000, 32'h34000000, 0, 0, 4, "R4");
        run_case(32'hBF800000, 32'h3F800000, 32'h00000000, 0, 0, 4, "R4");
        run_case(32'h80000000, 32'h80000000, 32'h00000000, 0, 0, 4, "R4");
    endtask

    task automatic t_zero_operand;
        run_case(32'h00000000, 32'h40490FDB, 32'h40490FDB, 0, 0, 4, "R2");
        run_case(32'h007FFFFF, 32'h3F800000, 32'h3F800000, 0, 0, 4, "R2");
    endtask

    task automatic t_rounding;
        run_case(32'h3F800000, 32'h33000000, 32'h3F800000, 0, 0, 4, "R5");
        run_case(32'h3F800000, 32'h33C00000, 32'h3F800001, 0, 0, 4, "R5");
        run_case(32'h3F800000, 32'h33800000, 32'h3F800000, 0, 0, 4, "R5");
        run_case(32'h3F800001, 32'h33800000, 32'h3F800002, 0, 0, 4, "R5");
    endtask

    task automatic t_far_apart;
        run_case(32'h3F800000, 32'h00800000, 32'h3F800000, 0, 0, 4, "R6");
        run_case(32'h3F800000, 32'h80800000, 32'h3F800000, 0, 0, 5, "R6");
    endtask

    task automatic t_round_carry;
        run_case(32'h3FFFFFFF, 32'h33800000, 32'h40000000, 0, 0, 5, "R7");
    endtask

    task automatic t_overflow;
        run_case(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1, 0, 4, "R8");
        run_case(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1, 0, 4, "R8");
        run_case(32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 1, 0, 5, "R8");
    endtask

    task automatic t_underflow;
        run_case(32'h00800001, 32'h80800000, 32'h00000000, 0, 1, 4, "R9");
        run_case(32'h00C00000, 32'h80800000, 32'h00000000, 0, 1, 4, "R9");
    endtask

    task automatic t_busy_start;
        int lat;
        int extra;
        @(negedge clk);
        op_a  = 32'h3F800000;
        op_b  = 32'h3F800000;
        start = 1'b1;
        @(negedge clk);
        op_a = 32'h40400000;
        op_b = 32'h40400000;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(sum == 32'h40000000, "R1", "busy start ignored", sum, 32'h40000000);
        chk(lat == 4, "R1", "busy latency", lat, 4);
        extra = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R1", "no extra done", extra, 0);
        chk(sum == 32'h40000000, "R1", "result held", sum, 32'h40000000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_like_sign();
        t_unlike_sign();
        t_zero_operand();
        t_rounding();
        t_far_apart();
        t_round_carry();
        t_overflow();
        t_underflow();
        t_busy_start();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule